// File: doc/BRIEF.md
# Lane Alignment Character Monitor

This block watches one decoded receive lane of a serial data link once the initial lane alignment sequence is over. It keeps a running octet position inside the multiframe. The multiframe is `FRAME_OCTETS × FRAMES_PER_MF` characters long. Each alignment control character that turns up in the user data is checked against that position. An alignment character belongs on the last octet of a multiframe. One misplaced character is tolerated. A second misplaced one in a row makes the block pulse a realignment request and reload its position counter, so that the offending character becomes the new multiframe end.

The block also records trouble in the lane's elastic buffer. It has two sticky flags, one for underflow (buffer empty) and one for overflow (buffer full). They are set only while the lane is being monitored. Each flag is cleared by writing one to its bit of a clear input.

The controller has three states. `ST_WAIT_ILA` waits for the sequence-done strobe. `ST_LOCKED` means monitoring with no outstanding miss. `ST_SUSPECT` means one misplaced alignment character has been seen.

The transitions are as follows:
- `ST_WAIT_ILA` → `ST_LOCKED` on `ila_done`.
- `ST_LOCKED` → `ST_SUSPECT` on a misplaced character.
- `ST_SUSPECT` → `ST_LOCKED` on a correctly placed character (miss cleared).
- `ST_SUSPECT` → `ST_LOCKED` on a second misplaced character (realign).
- Either monitoring state → `ST_LOCKED` on `ila_done` (restart).

Top module: `lane_align_mon`

## Requirements
- R1: After reset, `realign_req`, `mon_pos`, `err_underflow` and `err_overflow` are all 0.
- R2: Before the first `ila_done`, characters (alignment characters included) leave `mon_pos` at 0 and never raise `realign_req`.
- R3: After `ila_done`, `mon_pos` is 0 and advances by one for each cycle with `rx_valid` high. It wraps from `FRAME_OCTETS*FRAMES_PER_MF-1` to 0 and holds while `rx_valid` is low.
- R4: Only a character with `rx_char` = 0x7C and `rx_is_ctrl` = 1 counts as an alignment character. 0x7C as plain data, or any other control character, has no effect on alignment.
- R5: An alignment character received while `mon_pos` is the last multiframe position is correctly placed. It causes no request. A single misplaced alignment character also causes no request.
- R6: A second misplaced alignment character in a row raises `realign_req` for exactly one cycle, in the cycle after it is received. In that same cycle `mon_pos` reads 0.
- R7: A correctly placed alignment character between two misplaced ones clears the miss count, so no request follows.
- R8: `err_underflow` is set in the cycle after `buf_empty` is sampled high while monitoring. It stays set until cleared.
- R9: `err_overflow` is set in the cycle after `buf_full` is sampled high while monitoring. It stays set until cleared.
- R10: `err_clr[0]` clears `err_underflow` and `err_clr[1]` clears `err_overflow`, each without touching the other flag. A set condition in the same cycle wins over the clear.
- R11: Before the first `ila_done`, buffer conditions do not set either flag.
- R12: `ila_done` while monitoring restarts the position at 0 and drops any outstanding miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ila_done | input | 1 | Strobe: initial alignment sequence finished |
| rx_valid | input | 1 | A decoded character is present this cycle |
| rx_char | input | 8 | Decoded character value |
| rx_is_ctrl | input | 1 | Character is a control character |
| buf_empty | input | 1 | Elastic buffer is empty (underflow) |
| buf_full | input | 1 | Elastic buffer is full (overflow) |
| err_clr | input | 2 | Write-one-to-clear: bit 0 underflow, bit 1 overflow |
| realign_req | output | 1 | One-cycle realignment request |
| mon_pos | output | POS_W | Octet position inside the multiframe |
| err_underflow | output | 1 | Sticky underflow flag |
| err_overflow | output | 1 | Sticky overflow flag |

## Verification
The hardest condition to reach is the suspect state followed by a correctly placed character and then another miss. It needs the position counter steered to exact values, and the state itself is invisible at the ports. The stimulus first forces a realignment, because that pins `mon_pos` to a known 0. It then pads with data characters to place each alignment character on a chosen position. Whether a miss was counted is read back from whether the next misplaced character produces `realign_req`. The same trick shows that plain 0x7C data and other control characters were not counted as misses.

// File: rtl/lam_pkg.sv
package lam_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_ILA = 2'd0,
        ST_LOCKED   = 2'd1,
        ST_SUSPECT  = 2'd2
    } lam_state_e;

    localparam logic [7:0] ALIGN_CODE = 8'h7C;
    localparam int         NUM_ERR    = 2;
endpackage

// File: rtl/lam_char_detect.sv
module lam_char_detect #(
    parameter logic [7:0] CODE = 8'h7C
) (
    input  logic       rx_valid,
    input  logic [7:0] rx_char,
    input  logic       rx_is_ctrl,
    output logic       is_align
);
    always_comb begin
        is_align = rx_valid && rx_is_ctrl && (rx_char == CODE);
    end
endmodule

// File: rtl/lam_pos_counter.sv
module lam_pos_counter #(
    parameter int MF_LEN = 8,
    localparam int POS_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    output logic [POS_W-1:0] pos,
    output logic             at_end
);
    localparam logic [POS_W-1:0] LAST = POS_W'(MF_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (restart) begin
            pos <= '0;
        end else if (advance) begin
            pos <= (pos == LAST) ? '0 : pos + POS_W'(1);
        end
    end

    always_comb begin
        at_end = (pos == LAST);
    end
endmodule

// File: rtl/lam_err_flags.sv
module lam_err_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [N-1:0] set_in,
    input  logic [N-1:0] clr_in,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (enable && set_in[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_in[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lane_align_mon.sv
module lane_align_mon
    import lam_pkg::*;
#(
    parameter int FRAME_OCTETS  = 2,
    parameter int FRAMES_PER_MF = 4,
    localparam int MF_LEN = FRAME_OCTETS * FRAMES_PER_MF,
    localparam int POS_W  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ila_done,
    input  logic             rx_valid,
    input  logic [7:0]       rx_char,
    input  logic             rx_is_ctrl,
    input  logic             buf_empty,
    input  logic             buf_full,
    input  logic [1:0]       err_clr,
    output logic             realign_req,
    output logic [POS_W-1:0] mon_pos,
    output logic             err_underflow,
    output logic             err_overflow
);
    lam_state_e state, state_nxt;
    logic is_align, at_end, active, misplaced, placed, realign_fire, restart;
    logic [NUM_ERR-1:0] err_flags;

    lam_char_detect #(.CODE(ALIGN_CODE)) u_detect (
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .rx_is_ctrl(rx_is_ctrl),
        .is_align  (is_align)
    );

    always_comb begin
        active       = (state != ST_WAIT_ILA);
        misplaced    = active && !ila_done && is_align && !at_end;
        placed       = active && !ila_done && is_align && at_end;
        realign_fire = (state == ST_SUSPECT) && misplaced;
        restart      = ila_done || realign_fire;
    end

    lam_pos_counter #(.MF_LEN(MF_LEN)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .advance(active && rx_valid),
        .pos    (mon_pos),
        .at_end (at_end)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_ILA: if (ila_done) state_nxt = ST_LOCKED;
            ST_LOCKED: begin
                if (ila_done)       state_nxt = ST_LOCKED;
                else if (misplaced) state_nxt = ST_SUSPECT;
            end
            ST_SUSPECT: begin
                if (ila_done || misplaced || placed) state_nxt = ST_LOCKED;
            end
            default: state_nxt = ST_WAIT_ILA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_ILA;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) realign_req <= 1'b0;
        else        realign_req <= realign_fire;
    end

    lam_err_flags #(.N(NUM_ERR)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(active),
        .set_in({buf_full, buf_empty}),
        .clr_in(err_clr),
        .flags (err_flags)
    );

    always_comb begin
        err_underflow = err_flags[0];
        err_overflow  = err_flags[1];
    end
endmodule

// File: rtl/lane_align_mon_chk.sv
module lane_align_mon_chk #(
    parameter int MF_LEN = 8,
    localparam int POS_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ila_done,
    input logic             rx_valid,
    input logic             buf_empty,
    input logic             buf_full,
    input logic [1:0]       err_clr,
    input logic             active,
    input logic             realign_req,
    input logic [POS_W-1:0] mon_pos,
    input logic             err_underflow,
    input logic             err_overflow
);
    a_r2_idle_pos: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (mon_pos == '0));

    a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        mon_pos <= POS_W'(MF_LEN - 1));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !ila_done) |=> $stable(mon_pos));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        realign_req |=> !realign_req);

    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        realign_req |-> (mon_pos == '0));

    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (active && buf_empty) |=> err_underflow);

    a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
        (active && buf_full) |=> err_overflow);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_underflow && !err_clr[0]) |=> err_underflow);

    a_r11_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!err_underflow && !err_overflow));
endmodule

bind lane_align_mon lane_align_mon_chk #(.MF_LEN(MF_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ila_done     (ila_done),
    .rx_valid     (rx_valid),
    .buf_empty    (buf_empty),
    .buf_full     (buf_full),
    .err_clr      (err_clr),
    .active       (active),
    .realign_req  (realign_req),
    .mon_pos      (mon_pos),
    .err_underflow(err_underflow),
    .err_overflow (err_overflow)
);

// File: tb/lane_align_mon_tb.sv
`timescale 1ns/1ps
module lane_align_mon_tb;
    localparam int POS_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ila_done = 1'b0, rx_valid = 1'b0, rx_is_ctrl = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic buf_empty = 1'b0, buf_full = 1'b0;
    logic [1:0] err_clr = 2'b00;
    logic realign_req, err_underflow, err_overflow;
    logic [POS_W-1:0] mon_pos;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lane_align_mon #(.FRAME_OCTETS(2), .FRAMES_PER_MF(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .ila_done(ila_done), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_is_ctrl(rx_is_ctrl), .buf_empty(buf_empty),
        .buf_full(buf_full), .err_clr(err_clr), .realign_req(realign_req),
        .mon_pos(mon_pos), .err_underflow(err_underflow), .err_overflow(err_overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] c, input logic k,
                         input logic ila, input logic e, input logic f,
                         input logic [1:0] clr);
        @(negedge clk);
        rx_valid = v; rx_char = c; rx_is_ctrl = k; ila_done = ila;
        buf_empty = e; buf_full = f; err_clr = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] c, input logic k);
        drive(1'b1, c, k, 1'b0, 1'b0, 1'b0, 2'b00);
    endtask
    task automatic data();  send(8'h11, 1'b0); endtask
    task automatic align(); send(8'h7C, 1'b1); endtask
    task automatic idle();  drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00); endtask

    task automatic t_reset();
        #1;
        chk("R1 realign_req", realign_req, 0);
        chk("R1 mon_pos", mon_pos, 0);
        chk("R1 err_underflow", err_underflow, 0);
        chk("R1 err_overflow", err_overflow, 0);
    endtask

    task automatic t_idle();
        align(); data(); align(); align();
        chk("R2 pos before ila", mon_pos, 0);
        chk("R2 no realign before ila", realign_req, 0);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
        idle();
        chk("R11 underflow idle", err_underflow, 0);
        chk("R11 overflow idle", err_overflow, 0);
    endtask

    task automatic t_count();
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
        chk("R3 pos after ila", mon_pos, 0);
        data(); data(); data();
        chk("R3 pos advance", mon_pos, 3);
        idle();
        chk("R3 pos hold", mon_pos, 3);
        for (int i = 0; i < 5; i++) data();
        chk("R3 pos wrap", mon_pos, 0);
    endtask

    task automatic t_detect();
        for (int i = 0; i < 7; i++) data();
        chk("R5 pos at end", mon_pos, 7);
        align();
        chk("R5 placed no realign", realign_req, 0);
        chk("R5 pos after placed", mon_pos, 0);
        send(8'h7C, 1'b0); send(8'hBC, 1'b1); send(8'h7C, 1'b0); send(8'hBC, 1'b1);
        chk("R4 non-align no realign", realign_req, 0);
        chk("R4 pos", mon_pos, 4);
        align();
        chk("R5 single miss no realign", realign_req, 0);
        chk("R5 pos continues", mon_pos, 5);
    endtask

    task automatic t_realign();
        align();
        chk("R6 realign raised", realign_req, 1);
        chk("R6 pos reload", mon_pos, 0);
        data();
        chk("R6 realign one cycle", realign_req, 0);
        chk("R6 pos after reload", mon_pos, 1);
    endtask

    task automatic t_clear_miss();
        align();
        chk("R7 first miss", realign_req, 0);
        for (int i = 0; i < 5; i++) data();
        chk("R7 pos at end", mon_pos, 7);
        align();
        chk("R7 placed", realign_req, 0);
        align();
        chk("R7 miss after placed no realign", realign_req, 0);
        chk("R7 pos", mon_pos, 1);
        align();
        chk("R7 second miss realigns", realign_req, 1);
        chk("R7 pos reload", mon_pos, 0);
    endtask

    task automatic t_flags();
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00);
        chk("R8 underflow set", err_underflow, 1);
        chk("R8 overflow untouched", err_overflow, 0);
        idle();
        chk("R8 underflow sticky", err_underflow, 1);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
        idle();
        chk("R9 overflow set sticky", err_overflow, 1);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
        chk("R10 clear underflow", err_underflow, 0);
        chk("R10 overflow kept", err_overflow, 1);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10);
        chk("R10 set wins", err_overflow, 1);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
        chk("R10 clear overflow", err_overflow, 0);
    endtask

    task automatic t_restart();
        data(); data(); data();
        chk("R12 pos before restart", mon_pos, 3);
        align();
        drive(1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
        chk("R12 restart pos", mon_pos, 0);
        align();
        chk("R12 miss dropped", realign_req, 0);
        chk("R12 pos", mon_pos, 1);
    endtask

    initial begin
        t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_count();
        t_detect();
        t_realign();
        t_clear_miss();
        t_flags();
        t_restart();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule